// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page table held in memory. When a translation request is accepted, the walker splits the address into three fields. The top ten bits select an entry in the page directory, and the directory's page number comes from a base register. The next ten bits select an entry in the inner table that the directory entry points to. The low twelve bits are carried unchanged into the 4 KB frame named by the inner entry. The two table reads go out one after the other on a simple memory port: a valid/ready request and a valid-qualified response.

Each table entry is one 32-bit word. Bits 31..12 hold the page number of the next table or of the frame. Bit 0 marks the entry valid, bit 1 permits writes and bit 2 permits user-mode access. A clear valid bit at either level ends the walk with a fault instead of an address. The permission bits are checked against the request only at the leaf. The directory base register is loaded through a configuration port that takes a write only when a privilege qualifier is asserted. A request captures the base register value when it is accepted, so a base change never disturbs a walk already in progress.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the directory base page number is 0, so the first walk reads its directory entry at address 0 + index*4.
- R2: The directory entry is read at `{base_pn, 12'h000} + vaddr[31:22]*4`. `base_pn` is the directory page number that was in effect when the request was accepted.
- R3: After a valid directory entry D returns, exactly one more read is issued, at `{D[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: A walk whose leaf entry L is valid and permitted responds with `rsp_paddr = {L[31:12], vaddr[11:0]}`, `rsp_fault = 0` and `rsp_cause = 0`. `rsp_valid` is high for exactly one cycle.
- R5: A directory entry with bit 0 clear ends the walk after that single read, with `rsp_fault = 1`, `rsp_cause = 1` and `rsp_paddr = 0`.
- R6: A leaf entry with bit 0 clear ends the walk with `rsp_fault = 1`, `rsp_cause = 2` and `rsp_paddr = 0`.
- R7: Leaf bit 1 grants write and leaf bit 2 grants user access. A request with `req_write = 1` to a leaf with bit 1 clear, or with `req_user = 1` to a leaf with bit 2 clear, faults with `rsp_cause = 3` and `rsp_paddr = 0`. The permission bits of the directory entry are not checked.
- R8: `req_ready` is low from the cycle after a request is accepted through the cycle in which `rsp_valid` is high. It is high again in the following cycle.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged in the next cycle.
- R10: `cfg_wr` loads `cfg_base_pn` into the base register only when `cfg_priv` is 1. With `cfg_priv` at 0 the write has no effect.
- R11: A base register write made while a walk is in progress does not change that walk's directory address. It takes effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Base register write strobe |
| cfg_priv | input | 1 | Privilege qualifier for the write |
| cfg_base_pn | input | 20 | New directory page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 directory invalid, 2 leaf invalid, 3 permission |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The bench builds the walker with its default widths: a 32-bit address, a 12-bit offset and 10-bit indices at both levels. These values make both index extremes reachable. An address of all ones selects slot 1023 at both levels, so the last word of each table is read. Index 0 after reset checks that the base register starts at zero. The memory model can hold back its ready signal and stretch its response latency. This makes request holding and the busy window observable over many cycles, not only in the fastest walk.

// File: rtl/ptw_pkg.sv
// Package: shared types for the page table walker.
// Holds the walk state encoding, the fault cause codes and the bit
// positions of the control flags inside a table entry.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_PTE,
        ST_WAIT_PTE,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE         = 2'd0,
        CAUSE_DIR_INVALID  = 2'd1,
        CAUSE_LEAF_INVALID = 2'd2,
        CAUSE_PERM         = 2'd3
    } fault_cause_t;

    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_WRITE_BIT = 1;
    localparam int ENT_USER_BIT  = 2;
    localparam int ENT_BYTES_LOG = 2;

endpackage

// File: rtl/ptw_slot_addr.sv
// Module: ptw_slot_addr
// Computes the byte address of one table slot: a page-aligned table base
// plus the index scaled by the entry size.
// Assumes: a table fits in one page, so the scaled index stays inside the
// offset field (IDX_W + entry size log2 <= OFF_W).
module ptw_slot_addr
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] base_pn,
    input  logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-1:0]       slot_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - ENT_BYTES_LOG;

    // Scale the index by the entry size and add it to the aligned base.
    always_comb begin
        slot_addr = {base_pn, {OFF_W{1'b0}}}
                  + {{PAD_W{1'b0}}, idx, {ENT_BYTES_LOG{1'b0}}};
    end
endmodule

// File: rtl/ptw_leaf_check.sv
// Module: ptw_leaf_check
// Classifies a leaf entry against the access being translated: invalid,
// permission violation, or usable.
// Assumes: called only on the final level; directory entries never reach it.
module ptw_leaf_check
    import ptw_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             acc_write,
    input  logic             acc_user,
    output fault_cause_t     cause
);
    logic write_denied;
    logic user_denied;

    // Work out which permission the access lacks.
    always_comb begin
        write_denied = acc_write && !entry[ENT_WRITE_BIT];
        user_denied  = acc_user  && !entry[ENT_USER_BIT];
    end

    // Invalidity outranks permission problems.
    always_comb begin
        if (!entry[ENT_VALID_BIT])
            cause = CAUSE_LEAF_INVALID;
        else if (write_denied || user_denied)
            cause = CAUSE_PERM;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Translates a linear address through a directory and an inner table,
// one memory read per level, and returns a physical address or a fault.
// Assumes: the memory returns exactly one response per accepted read,
// never before the read is accepted; entries are ADDR_W bits wide and
// ADDR_W = OFF_W + 2*IDX_W.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_priv,
    input  logic [ADDR_W-OFF_W-1:0] cfg_base_pn,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int PN_W = ADDR_W - OFF_W;
    localparam int LVLS = 2;

    walk_state_t   state;
    logic [PN_W-1:0]   base_reg;
    logic [PN_W-1:0]   walk_base;
    logic [PN_W-1:0]   tbl_pn;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              usr_q;
    logic [ADDR_W-1:0] paddr_q;
    fault_cause_t      cause_q;
    fault_cause_t      leaf_cause;

    logic [PN_W-1:0]   lvl_base [LVLS];
    logic [ADDR_W-1:0] lvl_addr [LVLS];

    // Table base feeding each level: the snapshot base, then the directory pointer.
    always_comb begin
        lvl_base[0] = walk_base;
        lvl_base[1] = tbl_pn;
    end

    // One slot address generator per level, each fed its own index field.
    for (genvar g = 0; g < LVLS; g++) begin : g_level
        ptw_slot_addr #(
            .ADDR_W (ADDR_W),
            .OFF_W  (OFF_W),
            .IDX_W  (IDX_W)
        ) u_slot (
            .base_pn   (lvl_base[g]),
            .idx       (va_q[ADDR_W-1-g*IDX_W -: IDX_W]),
            .slot_addr (lvl_addr[g])
        );
    end

    ptw_leaf_check #(
        .ENT_W (ADDR_W)
    ) u_leaf (
        .entry     (mem_rsp_data),
        .acc_write (wr_q),
        .acc_user  (usr_q),
        .cause     (leaf_cause)
    );

    // Directory base register, loaded only by privileged writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_reg <= '0;
        else if (cfg_wr && cfg_priv)
            base_reg <= cfg_base_pn;
    end

    // Walk sequencer: captures the request, issues both reads, records the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            walk_base <= '0;
            tbl_pn    <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            usr_q     <= 1'b0;
            paddr_q   <= '0;
            cause_q   <= CAUSE_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        wr_q      <= req_write;
                        usr_q     <= req_user;
                        walk_base <= base_reg;
                        state     <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: begin
                    if (mem_req_ready)
                        state <= ST_WAIT_DIR;
                end
                ST_WAIT_DIR: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_data[ENT_VALID_BIT]) begin
                            cause_q <= CAUSE_DIR_INVALID;
                            paddr_q <= '0;
                            state   <= ST_DONE;
                        end else begin
                            tbl_pn <= mem_rsp_data[ADDR_W-1:OFF_W];
                            state  <= ST_READ_PTE;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (mem_req_ready)
                        state <= ST_WAIT_PTE;
                end
                ST_WAIT_PTE: begin
                    if (mem_rsp_valid) begin
                        cause_q <= leaf_cause;
                        paddr_q <= (leaf_cause == CAUSE_NONE)
                                 ? {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]}
                                 : '0;
                        state   <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port decode from the sequencer state and result registers.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_READ_DIR) || (state == ST_READ_PTE);
        mem_req_addr  = (state == ST_READ_PTE) ? lvl_addr[1] : lvl_addr[0];
        rsp_valid     = (state == ST_DONE);
        rsp_paddr     = paddr_q;
        rsp_cause     = cause_q;
        rsp_fault     = (cause_q != CAUSE_NONE);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R8
    AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0); // R5
    AST_RSP_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R8
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [19:0] cfg_base_pn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // memory model state
    logic [31:0] mem [logic [31:0]];
    bit          stall_on = 0;
    int          lat = 1;
    int          cnt;
    logic [31:0] pend;
    logic [3:0]  tick;
    logic [31:0] addr_log [8];
    int          rd_count;

    always #10 clk = ~clk;

    ptw_walker dut (
        .clk, .rst_n, .cfg_wr, .cfg_priv, .cfg_base_pn,
        .req_valid, .req_ready, .req_vaddr, .req_write, .req_user,
        .rsp_valid, .rsp_paddr, .rsp_fault, .rsp_cause,
        .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_data
    );

    always @(posedge clk) begin
        tick <= tick + 4'd1;
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            mem_req_ready <= 1'b0;
            cnt           <= 0;
            pend          <= '0;
            rd_count      <= 0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem.exists(pend) ? mem[pend] : 32'h0;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                pend               <= mem_req_addr;
                cnt                <= lat;
                addr_log[rd_count % 8] <= mem_req_addr;
                rd_count           <= rd_count + 1;
            end
            mem_req_ready <= !stall_on || (tick[1:0] == 2'b11);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit priv, input logic [19:0] pn);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_priv = priv; cfg_base_pn = pn;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_priv = 1'b0;
    endtask

    // Runs one translation and checks addresses, read count, result and busy window.
    task automatic do_walk(input string tag, input logic [31:0] va, input bit wr, input bit usr,
                           input logic [31:0] exp_dir, input logic [31:0] exp_pte,
                           input int exp_reads, input logic [31:0] exp_pa, input logic [1:0] exp_cause,
                           input bit mid_cfg, input logic [19:0] mid_pn);
        int start;
        int cyc;
        bit busy_ok;
        busy_ok = 1;
        cyc = 0;
        @(negedge clk);
        start = rd_count;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && cyc < 300) begin
            if (req_ready) busy_ok = 0;
            if (mid_cfg && cyc == 2) begin
                cfg_wr = 1'b1; cfg_priv = 1'b1; cfg_base_pn = mid_pn;
            end else begin
                cfg_wr = 1'b0; cfg_priv = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        cfg_wr = 1'b0; cfg_priv = 1'b0;
        chk({tag, " R8 ready low during walk"}, {31'd0, busy_ok & ~req_ready}, 32'd1);
        chk({tag, " R4 response arrived"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " R2 directory read address"}, addr_log[start % 8], exp_dir);
        chk({tag, " read count"}, rd_count - start, exp_reads);
        if (exp_reads == 2)
            chk({tag, " R3 leaf read address"}, addr_log[(start + 1) % 8], exp_pte);
        chk({tag, " paddr"}, rsp_paddr, exp_pa);
        chk({tag, " cause"}, {30'd0, rsp_cause}, {30'd0, exp_cause});
        chk({tag, " fault flag"}, {31'd0, rsp_fault}, {31'd0, exp_cause != 2'd0});
        @(negedge clk);
        chk({tag, " R8 ready back, R4 single pulse"}, {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic t_reset;
        chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
        // base register is 0: directory slot 0 at address 0, empty -> directory fault
        do_walk("R1 base zero", 32'h0000_0123, 0, 0, 32'h0, 32'h0, 1, 32'h0, 2'd1, 0, '0);
    endtask

    task automatic t_basic;
        cfg_write(1, 20'h00010);
        do_walk("R4 basic", 32'h0040_3ABC, 0, 0, 32'h0001_0004, 32'h0002_000C, 2,
                32'h1234_5ABC, 2'd0, 0, '0);
    endtask

    task automatic t_extremes;
        stall_on = 1; lat = 3;
        do_walk("R9 top indices stalled", 32'hFFFF_FFFF, 0, 0, 32'h0001_0FFC, 32'h0003_0FFC, 2,
                32'hABCD_EFFF, 2'd0, 0, '0);
        stall_on = 0; lat = 1;
    endtask

    task automatic t_dir_invalid;
        do_walk("R5 directory invalid", 32'h0080_0000, 0, 0, 32'h0001_0008, 32'h0, 1,
                32'h0, 2'd1, 0, '0);
    endtask

    task automatic t_leaf_invalid;
        do_walk("R6 leaf invalid", 32'h0040_4000, 0, 0, 32'h0001_0004, 32'h0002_0010, 2,
                32'h0, 2'd2, 0, '0);
    endtask

    task automatic t_perm;
        do_walk("R7 write to read-only", 32'h0040_5123, 1, 0, 32'h0001_0004, 32'h0002_0014, 2,
                32'h0, 2'd3, 0, '0);
        do_walk("R7 user read allowed", 32'h0040_5123, 0, 1, 32'h0001_0004, 32'h0002_0014, 2,
                32'h6666_6123, 2'd0, 0, '0);
        do_walk("R7 user to supervisor page", 32'h0040_6000, 0, 1, 32'h0001_0004, 32'h0002_0018, 2,
                32'h0, 2'd3, 0, '0);
        do_walk("R7 directory perms ignored", 32'h0040_3ABC, 1, 1, 32'h0001_0004, 32'h0002_000C, 2,
                32'h1234_5ABC, 2'd0, 0, '0);
    endtask

    task automatic t_unpriv;
        cfg_write(0, 20'h00099);
        do_walk("R10 unprivileged write ignored", 32'h0040_3ABC, 0, 0, 32'h0001_0004, 32'h0002_000C, 2,
                32'h1234_5ABC, 2'd0, 0, '0);
    endtask

    task automatic t_midwalk;
        stall_on = 1; lat = 2;
        do_walk("R11 walk keeps old base", 32'h0040_3ABC, 0, 0, 32'h0001_0004, 32'h0002_000C, 2,
                32'h1234_5ABC, 2'd0, 1, 20'h00050);
        stall_on = 0; lat = 1;
        do_walk("R11 R10 next walk uses new base", 32'h0040_3ABC, 0, 0, 32'h0005_0004, 32'h0, 1,
                32'h0, 2'd1, 0, '0);
    endtask

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_000C] = 32'h1234_5007;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'hABCD_E007;
        mem[32'h0001_0008] = 32'h0004_0000;
        mem[32'h0002_0010] = 32'h5555_5006;
        mem[32'h0002_0014] = 32'h6666_6005;
        mem[32'h0002_0018] = 32'h7777_7003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_dir_invalid();
        t_leaf_invalid();
        t_perm();
        t_unpriv();
        t_midwalk();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule